// File: doc/BRIEF.md
# Regulator setpoint and mode controller

This block is the digital decision core of a synchronous buck regulator. A 5-bit voltage-select code (a range bit above four code bits) is turned into a target setpoint in millivolts, with the setpoint held 1% above the nominal value that the code names. A digitised feedback sample is compared against windows placed around that setpoint, and one of four drive modes is chosen: proportional regulation, forced maximum duty, high-side driver off, or both drivers off.

The analog error path supplies a duty request every clock. The block passes it through in regulation, replaces it with a capped maximum during an undershoot, and zeroes it otherwise. Mode and setpoint change only at the end of each PWM period, so a driver never sees a mid-period switch. A shutdown input or an undervoltage flag on either supply is the only exception, and it forces both drivers off on the next clock.

Top module: `vr_mode_ctrl`

## Requirements
- R1: While reset is asserted and after its release, until the first period boundary, both drivers are off, `duty_cmd` is 0, `duty_ovr` is 0 and `setpoint_mv` is 0.
- R2: With the range bit (`vid_code[4]`) at 1 and code bits value d from 0 to 14, the nominal voltage is 3500 − 100·d mV and `setpoint_mv` reads floor(nominal·101/100) after the next boundary (10000 gives 3535, 11110 gives 2121).
- R3: With the range bit at 0 and d from 0 to 5, the nominal voltage is 2050 − 50·d mV and `setpoint_mv` reads floor(nominal·101/100) (00000 gives 2070, 00101 gives 1818).
- R4: Codes 00110 to 01111 and code 11111 are invalid: at the boundary both drivers turn off, `duty_cmd` is 0 and `setpoint_mv` reads 0.
- R5: When armed and 97·sp ≤ 100·fb ≤ 103·sp, the mode is regulation: `hs_en`=1, `ls_en`=1, `duty_ovr`=0 and `duty_cmd` = min(`duty_req`, DUTY_CAP), following `duty_req` every cycle.
- R6: When armed and 100·fb < 97·sp, the mode is forced duty: `hs_en`=1, `ls_en`=1, `duty_ovr`=1 and `duty_cmd` = DUTY_CAP (230 by default).
- R7: When 103·sp < 100·fb ≤ 110·sp, the high side is off: `hs_en`=0, `ls_en`=1, `duty_cmd`=0.
- R8: When 100·fb > 110·sp, both drivers turn off and `duty_cmd`=0, whether or not the block is armed.
- R9: After reset, a fault or an invalid code, the block is disarmed: an undershoot then yields regulation rather than forced duty, until a boundary at which 100·fb ≥ 97·sp arms it.
- R10: `shdn_n` low, `uv_core` high or `uv_drive` high turns both drivers off with `duty_cmd` 0 from the next clock and disarms the block.
- R11: Mode and setpoint are decided only at the clock edge where the period counter (0 after reset, counting to PWM_CYCLES−1) is at its last value; in between, the driver enables, `duty_ovr` and `setpoint_mv` hold unless a fault arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_code | input | 5 | Range bit (MSB) and four code bits, MSB first |
| shdn_n | input | 1 | Regulator enable; low shuts both drivers off |
| uv_core | input | 1 | Undervoltage flag of the logic supply |
| uv_drive | input | 1 | Undervoltage flag of the gate-drive supply |
| fb_mv | input | MV_W | Digitised output voltage in mV |
| duty_req | input | DUTY_W | Duty request from the error path |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |
| duty_cmd | output | DUTY_W | Duty passed to the modulator |
| duty_ovr | output | 1 | High when the maximum-duty override is active |
| setpoint_mv | output | MV_W | Registered target voltage in mV, 0 for an invalid code |

## Verification
The bench walks every one of the 32 codes with the feedback placed on each setpoint, so a decode with a wrong step, wrong step direction, missing 1% margin or a range boundary off by one shows up as a setpoint or mode mismatch. It drives the feedback exactly across the 97%, 103% and 110% edges, where a design that swapped strict and inclusive comparisons, or let the 110% trip wait for arming, would pick the wrong mode. It brings the output up from a low voltage after reset, after each fault and after an invalid code, where a design that armed too early would force maximum duty during start-up. Feedback changes in the middle of a period catch a design that decides every clock rather than once per period, and requests above the cap catch a missing clamp.

// File: rtl/vr_mode_pkg.sv
package vr_mode_pkg;

    typedef enum logic [1:0] {
        DRV_OFF    = 2'd0,
        DRV_REG    = 2'd1,
        DRV_BOOST  = 2'd2,
        DRV_HS_OFF = 2'd3
    } drv_mode_e;

    typedef struct packed {
        logic below;      // feedback under the lower window edge
        logic above;      // feedback over the upper window edge
        logic trip;       // feedback over the overvoltage trip level
    } win_flags_t;

endpackage

// File: rtl/vr_vid_decode.sv
module vr_vid_decode #(
    parameter int MV_W       = 12,
    parameter int HI_TOP_MV  = 3500,
    parameter int HI_STEP_MV = 100,
    parameter int HI_CODES   = 15,
    parameter int LO_TOP_MV  = 2050,
    parameter int LO_STEP_MV = 50,
    parameter int LO_CODES   = 6,
    parameter int MARGIN_PCT = 1
) (
    input  logic [4:0]      vid_i,
    output logic            valid_o,
    output logic [MV_W-1:0] setpoint_o
);

    localparam int SCALE = 100 + MARGIN_PCT;

    int idx;
    int nominal;
    int trimmed;

    always_comb begin
        idx = int'(vid_i[3:0]);
        if (vid_i[4]) begin
            valid_o = (idx < HI_CODES);
            nominal = HI_TOP_MV - HI_STEP_MV * idx;
        end else begin
            valid_o = (idx < LO_CODES);
            nominal = LO_TOP_MV - LO_STEP_MV * idx;
        end
        trimmed    = (nominal * SCALE) / 100;
        setpoint_o = valid_o ? MV_W'(trimmed) : '0;
    end

endmodule

// File: rtl/vr_window_cmp.sv
module vr_window_cmp
    import vr_mode_pkg::*;
#(
    parameter int MV_W     = 12,
    parameter int LO_PCT   = 97,
    parameter int HI_PCT   = 103,
    parameter int TRIP_PCT = 110
) (
    input  logic [MV_W-1:0] fb_i,
    input  logic [MV_W-1:0] sp_i,
    output win_flags_t      flags_o
);

    localparam int PROD_W = MV_W + 8;

    logic [PROD_W-1:0] fb_scaled;
    logic [PROD_W-1:0] lo_edge;
    logic [PROD_W-1:0] hi_edge;
    logic [PROD_W-1:0] trip_edge;

    always_comb begin
        fb_scaled     = PROD_W'(fb_i) * PROD_W'(100);
        lo_edge       = PROD_W'(sp_i) * PROD_W'(LO_PCT);
        hi_edge       = PROD_W'(sp_i) * PROD_W'(HI_PCT);
        trip_edge     = PROD_W'(sp_i) * PROD_W'(TRIP_PCT);
        flags_o.below = (fb_scaled < lo_edge);
        flags_o.above = (fb_scaled > hi_edge);
        flags_o.trip  = (fb_scaled > trip_edge);
    end

endmodule

// File: rtl/vr_period_timer.sv
module vr_period_timer #(
    parameter int PWM_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int CNT_W = (PWM_CYCLES > 1) ? $clog2(PWM_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWM_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/vr_mode_ctrl.sv
module vr_mode_ctrl
    import vr_mode_pkg::*;
#(
    parameter int MV_W       = 12,
    parameter int DUTY_W     = 8,
    parameter int DUTY_CAP   = 230,
    parameter int PWM_CYCLES = 16,
    parameter int HI_CODES   = 15,
    parameter int LO_CODES   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        vid_code,
    input  logic              shdn_n,
    input  logic              uv_core,
    input  logic              uv_drive,
    input  logic [MV_W-1:0]   fb_mv,
    input  logic [DUTY_W-1:0] duty_req,
    output logic              hs_en,
    output logic              ls_en,
    output logic [DUTY_W-1:0] duty_cmd,
    output logic              duty_ovr,
    output logic [MV_W-1:0]   setpoint_mv
);

    localparam logic [DUTY_W-1:0] CAP = DUTY_W'(DUTY_CAP);

    typedef struct packed {
        drv_mode_e       mode;
        logic            armed;
        logic [MV_W-1:0] setpoint;
    } ctrl_state_t;

    ctrl_state_t     st_d, st_q;
    logic            tick;
    logic            code_ok;
    logic [MV_W-1:0] code_sp;
    win_flags_t      win;
    logic            fault;

    vr_period_timer #(.PWM_CYCLES(PWM_CYCLES)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    vr_vid_decode #(
        .MV_W     (MV_W),
        .HI_CODES (HI_CODES),
        .LO_CODES (LO_CODES)
    ) decode_i (
        .vid_i      (vid_code),
        .valid_o    (code_ok),
        .setpoint_o (code_sp)
    );

    vr_window_cmp #(.MV_W(MV_W)) window_i (
        .fb_i    (fb_mv),
        .sp_i    (code_sp),
        .flags_o (win)
    );

    // next-state decision
    always_comb begin
        fault = !shdn_n || uv_core || uv_drive;
        st_d  = st_q;

        if (tick) begin
            st_d.setpoint = code_sp;
        end

        if (fault) begin
            st_d.mode  = DRV_OFF;
            st_d.armed = 1'b0;
        end else if (tick) begin
            if (!code_ok) begin
                st_d.mode  = DRV_OFF;
                st_d.armed = 1'b0;
            end else if (win.trip) begin
                st_d.mode  = DRV_OFF;
                st_d.armed = 1'b1;
            end else if (win.below) begin
                st_d.mode = st_q.armed ? DRV_BOOST : DRV_REG;
            end else if (win.above) begin
                st_d.mode  = DRV_HS_OFF;
                st_d.armed = 1'b1;
            end else begin
                st_d.mode  = DRV_REG;
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= DRV_OFF;
            st_q.armed    <= 1'b0;
            st_q.setpoint <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // output decode from the registered mode
    always_comb begin
        hs_en       = 1'b0;
        ls_en       = 1'b0;
        duty_cmd    = '0;
        duty_ovr    = 1'b0;
        setpoint_mv = st_q.setpoint;
        unique case (st_q.mode)
            DRV_REG: begin
                hs_en    = 1'b1;
                ls_en    = 1'b1;
                duty_cmd = (duty_req > CAP) ? CAP : duty_req;
            end
            DRV_BOOST: begin
                hs_en    = 1'b1;
                ls_en    = 1'b1;
                duty_cmd = CAP;
                duty_ovr = 1'b1;
            end
            DRV_HS_OFF: begin
                ls_en = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/vr_mode_ctrl_chk.sv
module vr_mode_ctrl_chk #(
    parameter int MV_W       = 12,
    parameter int DUTY_W     = 8,
    parameter int DUTY_CAP   = 230,
    parameter int PWM_CYCLES = 16,
    parameter int HI_CODES   = 15,
    parameter int LO_CODES   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        vid_code,
    input logic              shdn_n,
    input logic              uv_core,
    input logic              uv_drive,
    input logic              hs_en,
    input logic              ls_en,
    input logic [DUTY_W-1:0] duty_cmd,
    input logic              duty_ovr,
    input logic [MV_W-1:0]   setpoint_mv
);

    localparam int CNT_W = (PWM_CYCLES > 1) ? $clog2(PWM_CYCLES) : 1;

    logic [CNT_W-1:0] ref_cnt;
    logic             at_edge;
    logic             bad_code;
    logic             any_fault;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ref_cnt <= '0;
        else if (at_edge) ref_cnt <= '0;
        else              ref_cnt <= ref_cnt + 1'b1;
    end

    assign at_edge   = (ref_cnt == CNT_W'(PWM_CYCLES - 1));
    assign bad_code  = vid_code[4] ? (int'(vid_code[3:0]) >= HI_CODES)
                                   : (int'(vid_code[3:0]) >= LO_CODES);
    assign any_fault = !shdn_n || uv_core || uv_drive;

    AST_FAULT_DRIVERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        any_fault |=> (!hs_en && !ls_en && duty_cmd == '0)); // R10

    AST_INVALID_CODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (at_edge && bad_code) |=> (!hs_en && !ls_en && setpoint_mv == '0)); // R4

    AST_DUTY_UNDER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        duty_cmd <= DUTY_W'(DUTY_CAP)); // R5

    AST_OVERRIDE_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        duty_ovr |-> (hs_en && ls_en && duty_cmd == DUTY_W'(DUTY_CAP))); // R6

    AST_HIGH_SIDE_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> ls_en); // R7

    AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_edge && !any_fault) |=>
            ($stable(hs_en) && $stable(ls_en) && $stable(duty_ovr) && $stable(setpoint_mv))); // R11

endmodule

bind vr_mode_ctrl vr_mode_ctrl_chk #(
    .MV_W       (MV_W),
    .DUTY_W     (DUTY_W),
    .DUTY_CAP   (DUTY_CAP),
    .PWM_CYCLES (PWM_CYCLES),
    .HI_CODES   (HI_CODES),
    .LO_CODES   (LO_CODES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .vid_code    (vid_code),
    .shdn_n      (shdn_n),
    .uv_core     (uv_core),
    .uv_drive    (uv_drive),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .duty_cmd    (duty_cmd),
    .duty_ovr    (duty_ovr),
    .setpoint_mv (setpoint_mv)
);

// File: tb/vr_mode_ctrl_tb_top.sv
module vr_mode_ctrl_tb_top;

    localparam int P    = 16;
    localparam int MV_W = 12;
    localparam int DW   = 8;
    localparam int CAP  = 230;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    vid_code = 5'b10000;
    logic          shdn_n = 1'b0;
    logic          uv_core = 1'b0;
    logic          uv_drive = 1'b0;
    logic [MV_W-1:0] fb_mv = '0;
    logic [DW-1:0] duty_req = '0;
    logic          hs_en, ls_en, duty_ovr;
    logic [DW-1:0] duty_cmd;
    logic [MV_W-1:0] setpoint_mv;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int    em = 0;        // 0 off, 1 regulate, 2 forced duty, 3 high side off
    int    esp = 0;
    int    ecnt = 0;
    bit    earmed = 1'b0;
    bit    eupd = 1'b1;
    string etag = "R1";
    string sptag = "R1";

    always #2 clk = ~clk;

    vr_mode_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vid_code    (vid_code),
        .shdn_n      (shdn_n),
        .uv_core     (uv_core),
        .uv_drive    (uv_drive),
        .fb_mv       (fb_mv),
        .duty_req    (duty_req),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .duty_cmd    (duty_cmd),
        .duty_ovr    (duty_ovr),
        .setpoint_mv (setpoint_mv)
    );

    function automatic int nom_of(logic [4:0] c);
        int d = int'(c[3:0]);
        if (c[4]) return (d <= 14) ? 3500 - 100 * d : -1;
        return (d <= 5) ? 2050 - 50 * d : -1;
    endfunction

    function automatic int sp_of(logic [4:0] c);
        int n = nom_of(c);
        return (n < 0) ? 0 : (n * 101) / 100;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em = 0; esp = 0; ecnt = 0; earmed = 1'b0;
            eupd = 1'b1; etag = "R1"; sptag = "R1";
        end else begin
            bit tk;
            bit flt;
            int s;
            int f;
            tk   = (ecnt == P - 1);
            ecnt = tk ? 0 : ecnt + 1;
            flt  = !shdn_n || uv_core || uv_drive;
            eupd = 1'b0;
            if (tk) begin
                esp   = sp_of(vid_code);
                sptag = (nom_of(vid_code) < 0) ? "R4" : (vid_code[4] ? "R2" : "R3");
            end
            if (flt) begin
                em = 0; earmed = 1'b0; etag = "R10"; eupd = 1'b1;
            end else if (tk) begin
                eupd = 1'b1;
                s = sp_of(vid_code);
                f = int'(fb_mv);
                if (nom_of(vid_code) < 0) begin
                    em = 0; earmed = 1'b0; etag = "R4";
                end else if (f * 100 > s * 110) begin
                    em = 0; earmed = 1'b1; etag = "R8";
                end else if (f * 100 < s * 97) begin
                    if (earmed) begin em = 2; etag = "R6"; end
                    else        begin em = 1; etag = "R9"; end
                end else if (f * 100 > s * 103) begin
                    em = 3; earmed = 1'b1; etag = "R7";
                end else begin
                    em = 1; earmed = 1'b1; etag = "R5";
                end
            end
        end
    end

    // comparison every cycle, one ns after the falling edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            int xd;
            string mt;
            mt = eupd ? etag : "R11";
            xd = (em == 2) ? CAP : (em == 1) ? ((int'(duty_req) > CAP) ? CAP : int'(duty_req)) : 0;
            check(hs_en == (em == 1 || em == 2), mt, "hs_en", int'(hs_en), int'(em == 1 || em == 2));
            check(ls_en == (em != 0), mt, "ls_en", int'(ls_en), int'(em != 0));
            check(duty_ovr == (em == 2), mt, "duty_ovr", int'(duty_ovr), int'(em == 2));
            check(int'(duty_cmd) == xd, etag, "duty_cmd", int'(duty_cmd), xd);
            check(int'(setpoint_mv) == esp, sptag, "setpoint_mv", int'(setpoint_mv), esp);
        end
    end

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            duty_req = duty_req + 8'd37;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!hs_en && !ls_en && duty_cmd == '0 && setpoint_mv == '0, "R1", "reset outputs",
              int'({hs_en, ls_en}), 0);
        shdn_n   = 1'b1;
        vid_code = 5'b10000;
        fb_mv    = 12'd1000;           // start-up: undershoot must not force duty (R9)
        run(3 * P);
        check(duty_ovr == 1'b0, "R9", "no override while disarmed", int'(duty_ovr), 0);
        check(int'(setpoint_mv) == 3535, "R2", "setpoint 10000", int'(setpoint_mv), 3535);
        fb_mv = 12'd3535;              // arms, regulate (R5)
        run(2 * P);
        duty_req = 8'd250;
        #1;
        check(int'(duty_cmd) == CAP, "R5", "duty clamp", int'(duty_cmd), CAP);
        fb_mv = 12'd3000;              // undershoot after arming (R6)
        run(2 * P);
        check(duty_ovr && int'(duty_cmd) == CAP, "R6", "forced duty", int'(duty_cmd), CAP);
        fb_mv = 12'd3429;              // 342900 >= 342895: inside window
        run(P);
        fb_mv = 12'd3428;              // 342800 < 342895: below
        run(P);
        fb_mv = 12'd3641;              // 364100 <= 364105: inside
        run(P);
        fb_mv = 12'd3642;              // above the upper edge (R7)
        run(2 * P);
        check(!hs_en && ls_en, "R7", "high side off", int'(hs_en), 0);
        fb_mv = 12'd3888;              // 388800 <= 388850: still R7
        run(P);
        fb_mv = 12'd3889;              // trip (R8)
        run(2 * P);
        check(!hs_en && !ls_en, "R8", "trip off", int'(ls_en), 0);
        fb_mv = 12'd3535;
        run(P + 5);
        fb_mv = 12'd3000;              // mid-period change must wait (R11)
        run(3);
        fb_mv = 12'd3535;
        run(2 * P);

        // sweep all codes with feedback on the setpoint
        for (int c = 0; c < 32; c++) begin
            vid_code = 5'(c);
            fb_mv    = MV_W'(sp_of(5'(c)));
            run(2 * P);
            check(int'(setpoint_mv) == sp_of(5'(c)),
                  (nom_of(5'(c)) < 0) ? "R4" : (c >= 16 ? "R2" : "R3"),
                  "sweep setpoint", int'(setpoint_mv), sp_of(5'(c)));
        end
        vid_code = 5'b00000;
        fb_mv    = 12'd2070;
        run(2 * P);
        check(int'(setpoint_mv) == 2070, "R3", "setpoint 00000", int'(setpoint_mv), 2070);
        vid_code = 5'b00101;
        fb_mv    = 12'd1818;
        run(2 * P);
        check(int'(setpoint_mv) == 1818, "R3", "setpoint 00101", int'(setpoint_mv), 1818);
        vid_code = 5'b11110;
        fb_mv    = 12'd2121;
        run(2 * P);
        check(int'(setpoint_mv) == 2121, "R2", "setpoint 11110", int'(setpoint_mv), 2121);
        vid_code = 5'b00110;           // invalid (R4), then recover disarmed (R9)
        run(2 * P);
        check(!ls_en && setpoint_mv == '0, "R4", "invalid code", int'(setpoint_mv), 0);
        vid_code = 5'b11110;
        fb_mv    = 12'd1500;
        run(2 * P);
        check(!duty_ovr && hs_en, "R9", "re-start after invalid", int'(duty_ovr), 0);

        // faults (R10), each followed by a low start-up
        fb_mv = 12'd2121;
        run(2 * P);
        run(7);
        shdn_n = 1'b0;
        run(1);
        #1;
        check(!hs_en && !ls_en, "R10", "shutdown immediate", int'(ls_en), 0);
        run(P);
        shdn_n = 1'b1;
        fb_mv  = 12'd1900;
        run(2 * P);
        fb_mv = 12'd2121;
        run(2 * P);
        uv_core = 1'b1;
        run(P + 3);
        uv_core = 1'b0;
        run(2 * P);
        uv_drive = 1'b1;
        run(4);
        uv_drive = 1'b0;
        fb_mv    = 12'd1700;
        run(2 * P);
        fb_mv = 12'd2121;
        run(P);
        fb_mv = 12'd1700;
        run(2 * P);
        check(duty_ovr == 1'b1, "R6", "armed undershoot", int'(duty_ovr), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule